// File: doc/BRIEF.md
# APB Countdown Timer Bank

A bank of independent down-counting timers that sits behind an APB slave port. Each timer holds a load count, a control word and a live count. Once enabled, it counts down by one on every clock. When it expires it reloads and latches a level interrupt. The reload source depends on the mode. A periodic timer reloads its load count, so it makes a steady tick. A free-running timer reloads all ones, which gives software a long window to re-arm it. Software can also read the inverted count to measure elapsed time.

Each timer has its own interrupt line, and one combined line is the OR of them. A mask bit in the control word gates a timer's line and its masked status without touching the raw pending bit. Reading a timer's end-of-interrupt register clears that timer's pending bit. Reading the shared end-of-interrupt register clears every pending bit. A shared region also gives the masked and raw pending vectors and a fixed version word.

Top module: `apb_timer_bank`

## Requirements
- R1: After reset every register reads 0, except the version register. Every timer is disabled and free-running with its interrupt unmasked, and all interrupt outputs are low.
- R2: Timer n occupies five word registers starting at byte address n*0x14: load count +0x00, live count +0x04, control +0x08, end-of-interrupt +0x0C, masked status +0x10. The load count reads back as written. The control register keeps only bits [2:0] and reads back 0 in the other bits.
- R3: Control bit 0 enables the timer. On the access cycle that sets it from 0, the count takes the load count value. From then on it drops by one every clock.
- R4: With control bit 1 set (periodic), a timer that is enabled and holds a count of 1 or 0 expires on the next clock. On that clock it sets its raw pending bit and reloads the load count.
- R5: With control bit 1 clear (free-running), expiry reloads the count with all ones.
- R6: Control bit 2 masks the interrupt when set. The raw vector at 0xA8 shows pending bits whatever the mask. The per-timer status, the masked vector at 0xA0 and irq[n] each equal raw AND NOT mask.
- R7: A read of a timer's end-of-interrupt register returns 0 and clears only that timer's pending bit. An expiry on the same clock wins.
- R8: A read of 0xA4 returns 0 and clears the pending bits of all timers.
- R9: Clearing the enable bit freezes the count and keeps a pending interrupt.
- R10: A load count write while the timer is enabled leaves the running count alone. It takes effect at the next reload.
- R11: Writes to the live count, status, shared status and version registers are ignored. The version register at 0xAC returns the VERSION parameter, and pready is always 1.
- R12: irq_any is high when any irq[n] is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus and counter clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Always 1, no wait states |
| irq | output | NUM_TMR | Per-timer masked interrupt |
| irq_any | output | 1 | OR of all per-timer interrupts |

## Verification
Register writes and end-of-interrupt reads take effect on the access-phase edge, so an interrupt line changes from the next sample onward. Read data is combinational in the access phase and shows the count as it stood after the setup-phase edge. Each bus operation takes exactly two clocks. The bench therefore numbers every edge from the enabling access and works out each expected count from that number, for example load minus one on the first read after enabling. Expiry is checked on the edge that follows a count of 1, with idle cycles placed so that the sample falls just after it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int DATA_W = 32;

    typedef struct packed {
        logic mask;
        logic periodic;
        logic enable;
    } tmr_ctrl_t;

    typedef enum logic [3:0] {
        RK_NONE,
        RK_LOAD,
        RK_COUNT,
        RK_CTRL,
        RK_ACK,
        RK_STAT,
        RK_ALL_STAT,
        RK_ALL_ACK,
        RK_ALL_RAW,
        RK_VERSION
    } reg_kind_e;

endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
    import tmr_pkg::*;
#(
    parameter int NUM_TMR = 2,
    parameter int ADDR_W  = 8,
    parameter int IDX_W   = 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [IDX_W-1:0]  idx
);

    localparam int STRIDE   = 'h14;
    localparam int SHARED   = 'hA0;

    always_comb begin
        kind = RK_NONE;
        idx  = '0;
        for (int i = 0; i < NUM_TMR; i++) begin
            if (addr == ADDR_W'(i*STRIDE + 'h00)) begin kind = RK_LOAD;  idx = IDX_W'(i); end
            if (addr == ADDR_W'(i*STRIDE + 'h04)) begin kind = RK_COUNT; idx = IDX_W'(i); end
            if (addr == ADDR_W'(i*STRIDE + 'h08)) begin kind = RK_CTRL;  idx = IDX_W'(i); end
            if (addr == ADDR_W'(i*STRIDE + 'h0C)) begin kind = RK_ACK;   idx = IDX_W'(i); end
            if (addr == ADDR_W'(i*STRIDE + 'h10)) begin kind = RK_STAT;  idx = IDX_W'(i); end
        end
        if (addr == ADDR_W'(SHARED + 'h0)) kind = RK_ALL_STAT;
        if (addr == ADDR_W'(SHARED + 'h4)) kind = RK_ALL_ACK;
        if (addr == ADDR_W'(SHARED + 'h8)) kind = RK_ALL_RAW;
        if (addr == ADDR_W'(SHARED + 'hC)) kind = RK_VERSION;
    end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_load,
    input  logic             wr_ctrl,
    input  logic             clr,
    input  logic [CNT_W-1:0] wdata,
    input  tmr_ctrl_t        ctrl_in,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] load,
    output tmr_ctrl_t        ctrl,
    output logic             raw
);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] load;
        tmr_ctrl_t        ctrl;
        logic             raw;
    } chan_t;

    chan_t st_d, st_q;
    logic  expire;
    logic [CNT_W-1:0] reload;

    always_comb begin
        st_d   = st_q;
        expire = st_q.ctrl.enable && (st_q.count <= CNT_W'(1));
        reload = st_q.ctrl.periodic ? st_q.load : '1;

        if (st_q.ctrl.enable) begin
            st_d.count = expire ? reload : st_q.count - CNT_W'(1);
        end
        if (wr_load) begin
            st_d.load = wdata;
        end
        if (wr_ctrl) begin
            st_d.ctrl = ctrl_in;
            if (ctrl_in.enable && !st_q.ctrl.enable) begin
                st_d.count = st_q.load;
            end
        end
        if (clr) begin
            st_d.raw = 1'b0;
        end
        if (expire) begin
            st_d.raw = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.count;
    assign load  = st_q.load;
    assign ctrl  = st_q.ctrl;
    assign raw   = st_q.raw;

    // R3: enabling starts the count at the load value
    a_r3_start_from_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ctrl.enable) |-> st_q.count == st_q.load);

    // R3: a running count above 1 drops by exactly one
    a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.enable && st_q.count > CNT_W'(1)) |=> st_q.count == $past(st_q.count) - CNT_W'(1));

    // R4: expiry raises the pending bit even with a clear on the same clock
    a_r4_expiry_pends: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.enable && st_q.count <= CNT_W'(1)) |=> st_q.raw);

    // R4: periodic expiry reloads the load count
    a_r4_periodic_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.enable && st_q.ctrl.periodic && st_q.count <= CNT_W'(1))
        |=> st_q.count == $past(st_q.load));

    // R5: free-running expiry reloads all ones
    a_r5_free_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.enable && !st_q.ctrl.periodic && st_q.count <= CNT_W'(1))
        |=> st_q.count == '1);

    // R7: a clear without a coinciding expiry drops the pending bit
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !(st_q.ctrl.enable && st_q.count <= CNT_W'(1))) |=> !st_q.raw);

    // R9: a disabled timer holds its count until re-enabled
    a_r9_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.ctrl.enable |=> (st_q.ctrl.enable || $stable(st_q.count)));

endmodule

// File: rtl/apb_timer_bank.sv
module apb_timer_bank
    import tmr_pkg::*;
#(
    parameter int          NUM_TMR = 2,
    parameter int          CNT_W   = 32,
    parameter int          ADDR_W  = 8,
    parameter logic [31:0] VERSION = 32'h5444_0107
) (
    input  logic               pclk,
    input  logic               presetn,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [ADDR_W-1:0]  paddr,
    input  logic [31:0]        pwdata,
    output logic [31:0]        prdata,
    output logic               pready,
    output logic [NUM_TMR-1:0] irq,
    output logic               irq_any
);

    localparam int IDX_W = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1;

    reg_kind_e          kind;
    logic [IDX_W-1:0]   idx;
    logic               access, do_wr, do_rd;
    logic [NUM_TMR-1:0] wr_load, wr_ctrl, clr;
    logic [NUM_TMR-1:0] raw_vec, mask_vec;
    logic [CNT_W-1:0]   cnt_arr  [NUM_TMR];
    logic [CNT_W-1:0]   load_arr [NUM_TMR];
    tmr_ctrl_t          ctrl_arr [NUM_TMR];

    tmr_decode #(.NUM_TMR(NUM_TMR), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_dec (
        .addr (paddr),
        .kind (kind),
        .idx  (idx)
    );

    assign access = psel && penable;
    assign do_wr  = access && pwrite;
    assign do_rd  = access && !pwrite;

    always_comb begin
        for (int i = 0; i < NUM_TMR; i++) begin
            wr_load[i] = do_wr && kind == RK_LOAD && idx == IDX_W'(i);
            wr_ctrl[i] = do_wr && kind == RK_CTRL && idx == IDX_W'(i);
            clr[i]     = do_rd && ((kind == RK_ACK && idx == IDX_W'(i)) || kind == RK_ALL_ACK);
        end
    end

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
        tmr_channel #(.CNT_W(CNT_W)) i_chan (
            .clk     (pclk),
            .rst_n   (presetn),
            .wr_load (wr_load[g]),
            .wr_ctrl (wr_ctrl[g]),
            .clr     (clr[g]),
            .wdata   (pwdata[CNT_W-1:0]),
            .ctrl_in (tmr_ctrl_t'(pwdata[2:0])),
            .count   (cnt_arr[g]),
            .load    (load_arr[g]),
            .ctrl    (ctrl_arr[g]),
            .raw     (raw_vec[g])
        );
        assign mask_vec[g] = ctrl_arr[g].mask;
    end

    assign irq     = raw_vec & ~mask_vec;
    assign irq_any = |irq;
    assign pready  = 1'b1;

    always_comb begin
        prdata = '0;
        case (kind)
            RK_LOAD:     prdata[CNT_W-1:0]   = load_arr[idx];
            RK_COUNT:    prdata[CNT_W-1:0]   = cnt_arr[idx];
            RK_CTRL:     prdata[2:0]         = ctrl_arr[idx];
            RK_STAT:     prdata[0]           = irq[idx];
            RK_ALL_STAT: prdata[NUM_TMR-1:0] = irq;
            RK_ALL_RAW:  prdata[NUM_TMR-1:0] = raw_vec;
            RK_VERSION:  prdata              = VERSION;
            default:     prdata              = '0;
        endcase
    end

endmodule

// File: tb/test_apb_timer_bank.sv
module test_apb_timer_bank;

    localparam int          CLK_PERIOD = 10;
    localparam int          NT         = 2;
    localparam logic [31:0] VER        = 32'h5444_0107;

    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic [NT-1:0] irq;
    logic        irq_any;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    apb_timer_bank #(.NUM_TMR(NT), .CNT_W(32), .ADDR_W(8), .VERSION(VER)) i_apb_timer_bank (
        .pclk, .presetn, .psel, .penable, .pwrite, .paddr, .pwdata,
        .prdata, .pready, .irq, .irq_any
    );

    always #(CLK_PERIOD/2) pclk = ~pclk;

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h00, 32'h0},            // R1 load
        '{1'b0, 8'h04, 32'h0},            // R1 count
        '{1'b0, 8'h08, 32'h0},            // R1 control
        '{1'b0, 8'hA8, 32'h0},            // R1 raw
        '{1'b0, 8'hAC, VER},              // R11 version
        '{1'b1, 8'h00, 32'h1234_5678},
        '{1'b0, 8'h00, 32'h1234_5678},    // R2 load readback
        '{1'b1, 8'h14, 32'h0000_CAFE},
        '{1'b0, 8'h14, 32'h0000_CAFE},    // R2 timer 1 base 0x14
        '{1'b0, 8'h00, 32'h1234_5678},    // R2 timer 0 untouched
        '{1'b1, 8'h08, 32'hFFFF_FFF6},
        '{1'b0, 8'h08, 32'h0000_0006},    // R2 control keeps bits 2:0
        '{1'b1, 8'h08, 32'h0},
        '{1'b1, 8'h04, 32'h0000_ABCD},
        '{1'b0, 8'h04, 32'h0},            // R11 count read-only
        '{1'b1, 8'hAC, 32'h0},
        '{1'b0, 8'hAC, VER},              // R11 version read-only
        '{1'b1, 8'hA8, 32'hF},
        '{1'b0, 8'hA8, 32'h0}             // R11 raw read-only
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // both tasks start and end at a falling edge; two clocks each
    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge pclk);
        penable = 1'b1;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, input logic [31:0] exp, input string req);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge pclk);
        penable = 1'b1;
        #1;
        check(req, prdata, exp);
        check("R11 pready", {31'b0, pready}, 32'h1);
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge pclk);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge pclk);
        presetn = 1'b1;
        @(negedge pclk);
        check("R1 irq", {30'b0, irq}, 32'h0);
        check("R1 irq_any", {31'b0, irq_any}, 32'h0);

        for (int v = 0; v < NV; v++) begin
            if (VECS[v].wr) bus_wr(VECS[v].addr, VECS[v].data);
            else            bus_rd(VECS[v].addr, VECS[v].data, "R1/R2/R11 table");
        end

        // periodic timer 0, load 6; E = enabling access edge
        bus_wr(8'h00, 32'd6);
        bus_wr(8'h08, 32'h3);
        bus_rd(8'h04, 32'd5, "R3 first count");        // E+1
        bus_rd(8'h04, 32'd3, "R3 decrement");          // E+3
        idle(2);                                       // expiry at E+6
        check("R4 irq after expiry", {30'b0, irq}, 32'h1);
        check("R12 irq_any", {31'b0, irq_any}, 32'h1);
        bus_rd(8'h04, 32'd5, "R4 periodic reload");    // E+7
        bus_wr(8'h08, 32'h2);                          // disabled at E+10, count 2
        bus_rd(8'h04, 32'd2, "R9 frozen count");
        idle(3);
        bus_rd(8'h04, 32'd2, "R9 still frozen");
        check("R9 pending kept", {30'b0, irq}, 32'h1);

        // masking
        bus_wr(8'h08, 32'h6);
        check("R6 masked irq", {30'b0, irq}, 32'h0);
        check("R12 irq_any masked", {31'b0, irq_any}, 32'h0);
        bus_rd(8'hA8, 32'h1, "R6 raw ignores mask");
        bus_rd(8'h10, 32'h0, "R6 status masked");
        bus_rd(8'hA0, 32'h0, "R6 combined masked");
        bus_wr(8'h08, 32'h2);
        bus_rd(8'hA0, 32'h1, "R6 combined unmasked");

        // free-running timer 1, load 3
        bus_wr(8'h14, 32'd3);
        bus_wr(8'h1C, 32'h1);                          // E, count 3
        idle(3);                                       // expiry at E+3
        bus_rd(8'h18, 32'hFFFF_FFFE, "R5 free reload");
        check("R5 irq 1", {30'b0, irq}, 32'h3);
        bus_wr(8'h1C, 32'h0);

        // selective clear
        bus_rd(8'h20, 32'h0, "R7 ack returns 0");
        check("R7 only timer 1 cleared", {30'b0, irq}, 32'h1);
        bus_rd(8'h10, 32'h1, "R7 timer 0 still pending");
        bus_rd(8'h0C, 32'h0, "R7 ack timer 0");
        check("R7 all clear", {30'b0, irq}, 32'h0);
        check("R12 irq_any low", {31'b0, irq_any}, 32'h0);

        // combined clear
        bus_wr(8'h08, 32'h3);                          // E0
        bus_wr(8'h1C, 32'h1);                          // E0+2, expires E0+5
        idle(8);
        bus_wr(8'h08, 32'h2);
        bus_wr(8'h1C, 32'h0);
        check("R8 both pending", {30'b0, irq}, 32'h3);
        bus_rd(8'hA0, 32'h3, "R8 combined status");
        bus_rd(8'hA4, 32'h0, "R8 combined ack returns 0");
        check("R8 all cleared", {30'b0, irq}, 32'h0);
        bus_rd(8'hA8, 32'h0, "R8 raw cleared");

        // load write while running
        bus_wr(8'h08, 32'h3);                          // E, count 6
        bus_wr(8'h00, 32'd100);                        // E+2
        bus_rd(8'h04, 32'd3, "R10 count unaffected");  // E+3
        idle(2);                                       // reload at E+6
        bus_rd(8'h04, 32'd99, "R10 new load at reload");
        bus_wr(8'h08, 32'h0);
        bus_rd(8'h0C, 32'h0, "R7 ack");

        summary();
    end

endmodule